// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps the four 16-bit segment bases of a segmented memory model (code, data, extra and stack) together with an instruction pointer and a stack pointer. Each cycle it turns one segment:offset pair into a 20-bit physical address. The pair is picked by the kind of access the surrounding core is making. The physical address is the segment value shifted left by four bits plus the 16-bit offset, taken modulo 2^20. A segment can therefore start at any 16-byte boundary and span at most 64 KiB.

The core supplies the access kind: instruction fetch, data access, stack push or stack pop. For data accesses it also supplies the effective address, and it may name a segment that replaces the default data segment. A stack push moves the stack pointer down by one word before the access. A pop uses the current top and then moves the pointer up by one word. A write port loads any segment register, the instruction pointer or the stack pointer on the next clock edge. The physical address follows the current register values and inputs combinationally.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the registers take the values code segment = FFFFh and instruction pointer = data segment = extra segment = stack segment = stack pointer = 0000h. They keep these values for as long as `rst` stays high.
- R2: The physical address is (segment × 16 + offset) mod 2^20. For example, segment FFFFh with offset 0010h gives 00000h.
- R3: When `acc_kind` = 00 (fetch), the address uses the code segment with the instruction pointer as offset, whatever the override inputs hold.
- R4: When `acc_kind` = 10 (push), the address uses the stack segment with offset SP−2 (mod 2^16). If `acc_valid` is high, SP becomes SP−2 at the clock edge.
- R5: When `acc_kind` = 11 (pop), the address uses the stack segment with offset SP. If `acc_valid` is high, SP becomes SP+2 (mod 2^16) at the clock edge.
- R6: When `acc_kind` = 01 (data) and `seg_ovr_en` is low, the address uses the data segment with `eff_addr` as offset.
- R7: When `acc_kind` = 01 and `seg_ovr_en` is high, `seg_ovr_sel` picks the segment (00 extra, 01 code, 10 stack, 11 data). Fetch and stack accesses ignore the override.
- R8: When `wr_en` is high at a clock edge, `wr_sel` loads `wr_data` into one register (0 extra, 1 code, 2 stack segment, 3 data, 4 instruction pointer, 5 stack pointer). Codes 6 and 7 change no register.
- R9: If an SP write and a valid push or pop occur in the same cycle, the written value is kept and no adjustment is applied.
- R10: SP changes only on a valid push, a valid pop or an SP write. With `acc_valid` low, or on a fetch or data access, SP holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access is performed this cycle (enables SP adjustment) |
| acc_kind | input | 2 | 00 fetch, 01 data, 10 push, 11 pop |
| seg_ovr_en | input | 1 | Replace the data segment for a data access |
| seg_ovr_sel | input | 2 | Override segment: 00 extra, 01 code, 10 stack, 11 data |
| eff_addr | input | 16 | Effective address for data accesses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register written: 0 ES, 1 CS, 2 SS, 3 DS, 4 IP, 5 SP |
| wr_data | input | 16 | Value to write |
| phys_addr | output | 20 | Physical address |
| cs_q | output | 16 | Code segment |
| ds_q | output | 16 | Data segment |
| es_q | output | 16 | Extra segment |
| ss_q | output | 16 | Stack segment |
| ip_q | output | 16 | Instruction pointer |
| sp_q | output | 16 | Stack pointer |

## Verification
The assertions assume that `acc_kind`, `wr_en` and `wr_sel` carry known values at every clock edge after reset. They check SP steps only when no SP write shares the cycle. The bench drives every input to a defined value from time zero and changes inputs only just after a rising edge. The SP-write-during-push case is applied in one deliberate cycle, so each SP property sees exactly the input mix it describes.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_PUSH  = 2'd2,
    ACC_POP   = 2'd3
  } acc_kind_e;

  localparam logic [2:0] WSEL_IP = 3'd4;
  localparam logic [2:0] WSEL_SP = 3'd5;
  localparam int NUM_SEG = 4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int SP_STEP = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [2:0]                      wr_sel,
  input  logic [SEG_W-1:0]                wr_data,
  input  logic                            sp_dec,
  input  logic                            sp_inc,
  output logic [NUM_SEG-1:0][SEG_W-1:0]   segs,
  output logic [SEG_W-1:0]                ip_q,
  output logic [SEG_W-1:0]                sp_q
);
  localparam logic [SEG_W-1:0] STEP_V = SEG_W'(SP_STEP);

  logic sp_wr;
  assign sp_wr = wr_en && (wr_sel == WSEL_SP);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_V = (g == int'(SEG_CS)) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (rst)
        segs[g] <= RST_V;
      else if (wr_en && (wr_sel == 3'(g)))
        segs[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ip_q <= '0;
    else if (wr_en && (wr_sel == WSEL_IP))
      ip_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sp_q <= '0;
    else if (sp_wr)
      sp_q <= wr_data;
    else if (sp_dec)
      sp_q <= sp_q - STEP_V;
    else if (sp_inc)
      sp_q <= sp_q + STEP_V;
  end

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_dec && !sp_wr) |=> (sp_q == $past(sp_q) - STEP_V));

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_inc && !sp_wr) |=> (sp_q == $past(sp_q) + STEP_V));

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sp_dec && !sp_inc && !sp_wr) |=> $stable(sp_q));

  // R1
  reset_val_chk: assert property (@(posedge clk)
    rst |=> (segs[SEG_CS] == '1 && ip_q == '0 && sp_q == '0));
endmodule

// File: rtl/seg_sel.sv
module seg_sel
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int SP_STEP = 2
) (
  input  logic [1:0]                      acc_kind,
  input  logic                            ovr_en,
  input  logic [1:0]                      ovr_sel,
  input  logic [NUM_SEG-1:0][SEG_W-1:0]   segs,
  input  logic [SEG_W-1:0]                ip_q,
  input  logic [SEG_W-1:0]                sp_q,
  input  logic [SEG_W-1:0]                eff_addr,
  output logic [SEG_W-1:0]                base,
  output logic [SEG_W-1:0]                offset
);
  localparam logic [SEG_W-1:0] STEP_V = SEG_W'(SP_STEP);

  always_comb begin
    unique case (acc_kind)
      ACC_FETCH: begin
        base   = segs[SEG_CS];
        offset = ip_q;
      end
      ACC_PUSH: begin
        base   = segs[SEG_SS];
        offset = sp_q - STEP_V;
      end
      ACC_POP: begin
        base   = segs[SEG_SS];
        offset = sp_q;
      end
      default: begin
        base   = ovr_en ? segs[ovr_sel] : segs[SEG_DS];
        offset = eff_addr;
      end
    endcase
  end
endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] base,
  input  logic [SEG_W-1:0] offset,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] base_sh;
  assign base_sh = {base, {SHIFT{1'b0}}};
  assign addr    = base_sh + PA_W'(offset);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int SHIFT   = 4,
  parameter int SP_STEP = 2,
  localparam int PA_W   = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic             seg_ovr_en,
  input  logic [1:0]       seg_ovr_sel,
  input  logic [SEG_W-1:0] eff_addr,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  output logic [PA_W-1:0]  phys_addr,
  output logic [SEG_W-1:0] cs_q,
  output logic [SEG_W-1:0] ds_q,
  output logic [SEG_W-1:0] es_q,
  output logic [SEG_W-1:0] ss_q,
  output logic [SEG_W-1:0] ip_q,
  output logic [SEG_W-1:0] sp_q
);
  logic [NUM_SEG-1:0][SEG_W-1:0] segs;
  logic [SEG_W-1:0] base, offset;
  logic sp_dec, sp_inc;

  assign sp_dec = acc_valid && (acc_kind == ACC_PUSH);
  assign sp_inc = acc_valid && (acc_kind == ACC_POP);

  seg_regfile #(.SEG_W(SEG_W), .SP_STEP(SP_STEP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .segs(segs), .ip_q(ip_q), .sp_q(sp_q)
  );

  seg_sel #(.SEG_W(SEG_W), .SP_STEP(SP_STEP)) u_sel (
    .acc_kind(acc_kind), .ovr_en(seg_ovr_en), .ovr_sel(seg_ovr_sel),
    .segs(segs), .ip_q(ip_q), .sp_q(sp_q), .eff_addr(eff_addr),
    .base(base), .offset(offset)
  );

  phys_adder #(.SEG_W(SEG_W), .SHIFT(SHIFT)) u_add (
    .base(base), .offset(offset), .addr(phys_addr)
  );

  assign cs_q = segs[SEG_CS];
  assign ds_q = segs[SEG_DS];
  assign es_q = segs[SEG_ES];
  assign ss_q = segs[SEG_SS];

  // R3
  fetch_route_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_FETCH) |->
      (phys_addr - PA_W'({cs_q, {SHIFT{1'b0}}}) == PA_W'(ip_q)));

  // R8
  cs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd1) |=> (cs_q == $past(wr_data)));

  // R9
  sp_write_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == WSEL_SP) |=> (sp_q == $past(wr_data)));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic        seg_ovr_en = 1'b0;
  logic [1:0]  seg_ovr_sel = 2'd0;
  logic [15:0] eff_addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [19:0] phys_addr;
  logic [15:0] cs_q, ds_q, es_q, ss_q, ip_q, sp_q;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .seg_ovr_en(seg_ovr_en), .seg_ovr_sel(seg_ovr_sel), .eff_addr(eff_addr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .phys_addr(phys_addr),
    .cs_q(cs_q), .ds_q(ds_q), .es_q(es_q), .ss_q(ss_q), .ip_q(ip_q), .sp_q(sp_q)
  );

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    return 20'({4'h0, s} * 16 + {4'h0, o});
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] sp_exp;
    repeat (4) tick();
    rst = 1'b0;
    // R1 reset values
    check("R1 cs", cs_q, 16'hFFFF); check("R1 ip", ip_q, 0);
    check("R1 ds", ds_q, 0); check("R1 es", es_q, 0);
    check("R1 ss", ss_q, 0); check("R1 sp", sp_q, 0);

    // R8 writes to each register, then unused codes
    wr(3'd0, 16'h1111); check("R8 es", es_q, 16'h1111);
    wr(3'd1, 16'h2222); check("R8 cs", cs_q, 16'h2222);
    wr(3'd2, 16'h3333); check("R8 ss", ss_q, 16'h3333);
    wr(3'd3, 16'h4444); check("R8 ds", ds_q, 16'h4444);
    wr(3'd4, 16'h5555); check("R8 ip", ip_q, 16'h5555);
    wr(3'd5, 16'h6666); check("R8 sp", sp_q, 16'h6666);
    wr(3'd6, 16'hDEAD); wr(3'd7, 16'hBEEF);
    check("R8 unused", {es_q, cs_q}, 32'h11112222);
    check("R8 unused", {ss_q, ds_q}, 32'h33334444);
    check("R8 unused", {ip_q, sp_q}, 32'h55556666);

    // R6 / R2 sweep of data segment and effective address
    acc_kind = 2'd1; seg_ovr_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      wr(3'd3, 16'(i * 16'h1111));
      for (int j = 0; j < 17; j++) begin
        eff_addr = (j < 16) ? 16'(j * 16'h1111) : 16'h0010;
        #1;
        check("R6 R2 data", phys_addr, pa(16'(i * 16'h1111), eff_addr));
      end
    end
    // R2 wrap corner
    wr(3'd3, 16'hFFFF); eff_addr = 16'h0010; #1;
    check("R2 wrap", phys_addr, 20'h00000);

    // R7 override routing
    wr(3'd0, 16'h1234); wr(3'd1, 16'hABCD); wr(3'd2, 16'h0F0F); wr(3'd3, 16'h7000);
    eff_addr = 16'h0456; seg_ovr_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] sx;
      seg_ovr_sel = 2'(k);
      sx = (k == 0) ? 16'h1234 : (k == 1) ? 16'hABCD : (k == 2) ? 16'h0F0F : 16'h7000;
      #1;
      check("R7 override", phys_addr, pa(sx, 16'h0456));
    end
    wr(3'd4, 16'h0056); wr(3'd5, 16'h0100);
    seg_ovr_sel = 2'd0; acc_kind = 2'd0; #1;
    check("R7 fetch ignores override", phys_addr, pa(16'hABCD, 16'h0056));
    acc_kind = 2'd3; #1;
    check("R7 pop ignores override", phys_addr, pa(16'h0F0F, 16'h0100));
    seg_ovr_en = 1'b0;

    // R3 fetch sweep under CS=FFFF (wrapping)
    acc_kind = 2'd0;
    wr(3'd1, 16'hFFFF);
    for (int j = 0; j < 16; j++) begin
      wr(3'd4, 16'(j * 16'h1001));
      check("R3 fetch", phys_addr, pa(16'hFFFF, 16'(j * 16'h1001)));
    end
    // R10 fetch with valid leaves SP
    acc_valid = 1'b1; tick(); acc_valid = 1'b0;
    check("R10 fetch sp", sp_q, 16'h0100);

    // R4 pushes across zero
    wr(3'd2, 16'h2000); wr(3'd5, 16'h0004);
    sp_exp = 16'h0004;
    acc_kind = 2'd2;
    for (int p = 0; p < 3; p++) begin
      #1;
      check("R4 push addr", phys_addr, pa(16'h2000, 16'(sp_exp - 16'd2)));
      acc_valid = 1'b1; tick(); acc_valid = 1'b0;
      sp_exp = sp_exp - 16'd2;
      check("R4 push sp", sp_q, sp_exp);
    end
    // R5 pops back
    acc_kind = 2'd3;
    for (int p = 0; p < 3; p++) begin
      #1;
      check("R5 pop addr", phys_addr, pa(16'h2000, sp_exp));
      acc_valid = 1'b1; tick(); acc_valid = 1'b0;
      sp_exp = sp_exp + 16'd2;
      check("R5 pop sp", sp_q, sp_exp);
    end
    // R10 no valid: SP holds
    acc_kind = 2'd2; tick();
    check("R10 idle push", sp_q, 16'h0004);
    acc_kind = 2'd1; acc_valid = 1'b1; tick(); acc_valid = 1'b0;
    check("R10 data sp", sp_q, 16'h0004);

    // R9 SP write during push
    acc_kind = 2'd2; acc_valid = 1'b1;
    wr(3'd5, 16'h1000);
    acc_valid = 1'b0;
    check("R9 write wins", sp_q, 16'h1000);

    // R1 reset held mid-run
    rst = 1'b1; tick(); tick();
    check("R1 held cs", cs_q, 16'hFFFF);
    check("R1 held sp", sp_q, 16'h0000);
    check("R1 held ds", ds_q, 16'h0000);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule